// File: doc/BRIEF.md
# External Memory Bus Strobe Generator

This block drives the two timing strobes of a multiplexed external memory bus: an active-high address-latch-enable pulse (`ale_o`) and an active-low program-store-enable read strobe (`psen_n_o`). A separate machine-cycle sequencer supplies the current phase (0 to 11) of the 12-clock machine cycle. Per-cycle control flags say whether code is being fetched from external memory, whether the cycle performs an external data memory transfer, and whether it performs a code-table read. A control bit (`ale_dis_i`, reset value 0 in the register that feeds it) lets software silence the address latch pulse on the pin when it is not needed.

In a normal machine cycle the address strobe fires twice, once at the start of each half cycle, so it runs at one sixth of the clock rate. A cycle that moves external data drops the second address pulse and both read strobes. When the disable bit is set and code runs from internal memory, the address pulse appears only in cycles that move external data or read a code table. In all other cycles the block raises `ale_weak_pu_o` so the pin is only held high by a weak pull-up. While code runs from external memory the disable bit has no effect. All outputs are registered and follow the phase input by one clock.

Top module: `xbus_strobe_gen`

## Requirements
- R1: The clock after `rst` is sampled high, `ale_o` is 0, `psen_n_o` is 1 and `ale_weak_pu_o` is 0. The stored cycle flags, including the disable bit, clear to 0.
- R2: Each output takes the value decoded from the `phase_i` present at the previous clock edge (one clock of latency). In an enabled cycle, `ale_o` is 1 for phases 0, 1, 6 and 7 and 0 for every other phase.
- R3: The four control inputs are captured when `phase_i` is 0 and govern the whole machine cycle. Changes to them at phases 1 to 11 have no effect on any output until the next phase 0.
- R4: In a cycle with `xdata_i` set, the address pulse at phases 6 and 7 is omitted and the pulse at phases 0 and 1 is kept, so exactly one pulse is lost.
- R5: When `ale_dis_i` is 1 and `ext_exec_i` is 0, `ale_o` pulses only in cycles with `xdata_i` or `code_rd_i` set. In a cycle with neither set, `ale_o` stays 0 for the whole cycle.
- R6: `ale_weak_pu_o` is 1 exactly for the machine cycles in which the address pulse is suppressed by the disable bit (R5). It is never 1 while `ale_o` is 1.
- R7: With `ext_exec_i` at 1, `ale_dis_i` has no effect: `ale_o` behaves as in R2 and R4, and `ale_weak_pu_o` stays 0.
- R8: In a cycle with `ext_exec_i` set and `xdata_i` clear, `psen_n_o` is 0 for phases 3 to 5 and 9 to 11 (two strobes) and 1 otherwise. With `xdata_i` set, both strobes are suppressed. The read strobe is never active while `ale_o` is 1.
- R9: In a cycle with `ext_exec_i` clear, `psen_n_o` stays 1.
- R10: A `phase_i` value of 12 or above produces `ale_o` = 0 and `psen_n_o` = 1. It does not count as phase 0, so it does not capture new control inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_i | input | PH_W (4) | Current phase of the machine cycle, 0 to CYC_LEN-1 |
| ext_exec_i | input | 1 | Code is fetched from external program memory this cycle |
| xdata_i | input | 1 | This cycle transfers external data memory |
| code_rd_i | input | 1 | This cycle reads a code table |
| ale_dis_i | input | 1 | Address-latch pulse disable control bit |
| ale_o | output | 1 | Address latch enable, active high |
| psen_n_o | output | 1 | Program store enable, active low |
| ale_weak_pu_o | output | 1 | Address latch pin left to a weak pull-up |

## Verification
A wrong stored cycle context shows within the same machine cycle. A stale data-transfer flag either drops the phase-6 address pulse of a normal cycle or leaves a read strobe in a data cycle. A stale disable or execution flag wrongly silences or revives `ale_o` and flips `ale_weak_pu_o` from the next phase-0 clock onward. A wrong phase window decode moves a strobe edge by one clock, so it is caught at the first cycle that uses that window. The bench scrambles the control inputs in the middle of cycles, so a context that samples at the wrong phase is seen at the next output edge.

// File: rtl/xbsg_pkg.sv
package xbsg_pkg;

  // Per machine-cycle control context, captured at phase 0.
  typedef struct packed {
    logic ext_exec;
    logic xdata;
    logic code_rd;
    logic ale_dis;
  } cyc_ctx_t;

  // Address pulse allowed in this cycle: disable bit only bites while
  // running from internal code, and external moves/table reads override it.
  function automatic logic ale_allowed(cyc_ctx_t c);
    return !(c.ale_dis && !c.ext_exec) || c.xdata || c.code_rd;
  endfunction

  // Read strobe allowed in this cycle.
  function automatic logic psen_allowed(cyc_ctx_t c);
    return c.ext_exec && !c.xdata;
  endfunction

endpackage

// File: rtl/xbsg_window.sv
// Decodes a contiguous phase window [START, START+LEN-1].
module xbsg_window #(
  parameter int PH_W  = 4,
  parameter int START = 0,
  parameter int LEN   = 2
) (
  input  logic [PH_W-1:0] phase_i,
  output logic            hit_o
);
  localparam int LAST = START + LEN - 1;

  int ph;
  always_comb begin
    ph    = int'(phase_i);
    hit_o = (ph >= START) && (ph <= LAST);
  end
endmodule

// File: rtl/xbsg_ctx_latch.sv
// Holds the control context for the running machine cycle.
module xbsg_ctx_latch
  import xbsg_pkg::*;
#(
  parameter int PH_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PH_W-1:0] phase_i,
  input  cyc_ctx_t        ctx_in,
  output cyc_ctx_t        ctx_cur
);
  cyc_ctx_t ctx_q;
  logic     cyc_start;

  assign cyc_start = (phase_i == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctx_q <= '0;
    end else if (cyc_start) begin
      ctx_q <= ctx_in;
    end
  end

  // At phase 0 the fresh inputs already govern the cycle.
  assign ctx_cur = cyc_start ? ctx_in : ctx_q;
endmodule

// File: rtl/xbsg_ale_unit.sv
// Address latch pulse generation with data-cycle skip and disable gating.
module xbsg_ale_unit
  import xbsg_pkg::*;
#(
  parameter int PH_W      = 4,
  parameter int N_SLOTS   = 2,
  parameter int SLOT_LEN  = 6,
  parameter int ALE_W     = 2,
  parameter int SKIP_SLOT = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PH_W-1:0] phase_i,
  input  cyc_ctx_t        ctx,
  output logic            ale_o,
  output logic            weak_pu_o
);
  logic [N_SLOTS-1:0] slot_hit;
  logic [N_SLOTS-1:0] slot_en;
  logic               gate;

  assign gate = ale_allowed(ctx);

  for (genvar k = 0; k < N_SLOTS; k++) begin : g_slot
    localparam bit IS_SKIP = (k == SKIP_SLOT);
    xbsg_window #(
      .PH_W (PH_W),
      .START(k * SLOT_LEN),
      .LEN  (ALE_W)
    ) u_win (
      .phase_i(phase_i),
      .hit_o  (slot_hit[k])
    );
    assign slot_en[k] = gate && !(IS_SKIP && ctx.xdata);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_o     <= 1'b0;
      weak_pu_o <= 1'b0;
    end else begin
      ale_o     <= |(slot_hit & slot_en);
      weak_pu_o <= !gate;
    end
  end
endmodule

// File: rtl/xbsg_psen_unit.sv
// Program store read strobe: one active-low window per half cycle.
module xbsg_psen_unit
  import xbsg_pkg::*;
#(
  parameter int PH_W     = 4,
  parameter int N_SLOTS  = 2,
  parameter int SLOT_LEN = 6,
  parameter int PSEN_OFS = 3,
  parameter int PSEN_W   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PH_W-1:0] phase_i,
  input  cyc_ctx_t        ctx,
  output logic            psen_n_o
);
  logic [N_SLOTS-1:0] win_hit;

  for (genvar k = 0; k < N_SLOTS; k++) begin : g_win
    xbsg_window #(
      .PH_W (PH_W),
      .START(k * SLOT_LEN + PSEN_OFS),
      .LEN  (PSEN_W)
    ) u_win (
      .phase_i(phase_i),
      .hit_o  (win_hit[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      psen_n_o <= 1'b1;
    end else begin
      psen_n_o <= !(psen_allowed(ctx) && (|win_hit));
    end
  end
endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
  import xbsg_pkg::*;
#(
  parameter int CYC_LEN  = 12,
  parameter int N_SLOTS  = 2,
  parameter int ALE_W    = 2,
  parameter int PSEN_OFS = 3,
  parameter int PSEN_W   = 3,
  parameter int PH_W     = $clog2(CYC_LEN + 4)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PH_W-1:0] phase_i,
  input  logic            ext_exec_i,
  input  logic            xdata_i,
  input  logic            code_rd_i,
  input  logic            ale_dis_i,
  output logic            ale_o,
  output logic            psen_n_o,
  output logic            ale_weak_pu_o
);
  localparam int SLOT_LEN  = CYC_LEN / N_SLOTS;
  localparam int SKIP_SLOT = N_SLOTS - 1;

  cyc_ctx_t ctx_in;
  cyc_ctx_t ctx_cur;

  assign ctx_in = '{ext_exec: ext_exec_i, xdata: xdata_i,
                    code_rd: code_rd_i, ale_dis: ale_dis_i};

  xbsg_ctx_latch #(.PH_W(PH_W)) u_ctx (
    .clk    (clk),
    .rst    (rst),
    .phase_i(phase_i),
    .ctx_in (ctx_in),
    .ctx_cur(ctx_cur)
  );

  xbsg_ale_unit #(
    .PH_W     (PH_W),
    .N_SLOTS  (N_SLOTS),
    .SLOT_LEN (SLOT_LEN),
    .ALE_W    (ALE_W),
    .SKIP_SLOT(SKIP_SLOT)
  ) u_ale (
    .clk      (clk),
    .rst      (rst),
    .phase_i  (phase_i),
    .ctx      (ctx_cur),
    .ale_o    (ale_o),
    .weak_pu_o(ale_weak_pu_o)
  );

  xbsg_psen_unit #(
    .PH_W    (PH_W),
    .N_SLOTS (N_SLOTS),
    .SLOT_LEN(SLOT_LEN),
    .PSEN_OFS(PSEN_OFS),
    .PSEN_W  (PSEN_W)
  ) u_psen (
    .clk     (clk),
    .rst     (rst),
    .phase_i (phase_i),
    .ctx     (ctx_cur),
    .psen_n_o(psen_n_o)
  );
endmodule

// File: rtl/xbsg_checker.sv
module xbsg_checker #(
  parameter int PH_W  = 4,
  parameter int ALE_W = 2
) (
  input logic            clk,
  input logic            rst,
  input logic [PH_W-1:0] phase_i,
  input logic            ext_exec_i,
  input logic            xdata_i,
  input logic            ale_o,
  input logic            psen_n_o,
  input logic            ale_weak_pu_o
);
  logic [7:0] ale_run;
  logic       chk_ext;
  logic       chk_xd;
  logic       start;

  assign start = (phase_i == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_run <= '0;
      chk_ext <= 1'b0;
      chk_xd  <= 1'b0;
    end else begin
      if (!ale_o) ale_run <= '0;
      else if (ale_run != 8'hFF) ale_run <= ale_run + 8'd1;
      if (start) begin
        chk_ext <= ext_exec_i;
        chk_xd  <= xdata_i;
      end
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!ale_o && psen_n_o && !ale_weak_pu_o));

  assert_ale_width_R2: assert property (@(posedge clk) disable iff (rst)
    int'(ale_run) <= ALE_W);

  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (rst)
    !(ale_o && !psen_n_o));

  assert_weak_pu_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    ale_weak_pu_o |-> !ale_o);

  assert_no_psen_internal_R9: assert property (@(posedge clk) disable iff (rst)
    (start ? !ext_exec_i : !chk_ext) |=> psen_n_o);

  assert_no_psen_data_R8: assert property (@(posedge clk) disable iff (rst)
    (start ? xdata_i : chk_xd) |=> psen_n_o);
endmodule

bind xbus_strobe_gen xbsg_checker #(.PH_W(PH_W), .ALE_W(ALE_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .phase_i      (phase_i),
  .ext_exec_i   (ext_exec_i),
  .xdata_i      (xdata_i),
  .ale_o        (ale_o),
  .psen_n_o     (psen_n_o),
  .ale_weak_pu_o(ale_weak_pu_o)
);

// File: tb/xbus_strobe_gen_tb.sv
`timescale 1ns/1ps
module xbus_strobe_gen_tb;
  localparam int PH_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PH_W-1:0] phase_i = '0;
  logic ext_exec_i = 1'b0, xdata_i = 1'b0, code_rd_i = 1'b0, ale_dis_i = 1'b0;
  logic ale_o, psen_n_o, ale_weak_pu_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // model of the captured cycle context
  bit m_ee, m_xd, m_cr, m_dis;

  always #4 clk = ~clk;

  xbus_strobe_gen u_dut (
    .clk(clk), .rst(rst), .phase_i(phase_i),
    .ext_exec_i(ext_exec_i), .xdata_i(xdata_i), .code_rd_i(code_rd_i),
    .ale_dis_i(ale_dis_i),
    .ale_o(ale_o), .psen_n_o(psen_n_o), .ale_weak_pu_o(ale_weak_pu_o)
  );

  task automatic chk(string tag, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit gate_f();
    return !(m_dis && !m_ee) || m_xd || m_cr;
  endfunction

  function automatic bit exp_ale_f(int ph);
    return gate_f() && ((ph inside {[0:1]}) || ((ph inside {[6:7]}) && !m_xd));
  endfunction

  function automatic bit exp_psen_n_f(int ph);
    return !(m_ee && !m_xd && (ph inside {[3:5], [9:11]}));
  endfunction

  function automatic string ale_tag_f(int ph);
    if (ph >= 12) return "R10";
    if (m_xd && (ph inside {[6:7]})) return "R4";
    if (m_dis && !m_ee) return "R5";
    if (m_dis && m_ee) return "R7";
    return "R2";
  endfunction

  // Drive one clock worth of inputs (called right after a negedge),
  // then compare outputs after the next rising edge.
  task automatic step(int ph, bit ee, bit xd, bit cr, bit dis, string tag);
    bit e_ale, e_psn, e_wpu;
    string ta, tp, tw;
    phase_i    = ph[PH_W-1:0];
    ext_exec_i = ee; xdata_i = xd; code_rd_i = cr; ale_dis_i = dis;
    if (ph == 0) begin
      m_ee = ee; m_xd = xd; m_cr = cr; m_dis = dis;
    end
    e_ale = exp_ale_f(ph);
    e_psn = exp_psen_n_f(ph);
    e_wpu = !gate_f();
    ta = ale_tag_f(ph);
    tp = (ph >= 12) ? "R10" : (m_ee ? "R8" : "R9");
    tw = (m_ee && m_dis) ? "R7" : "R6";
    if (tag != "") begin ta = tag; tp = tag; tw = tag; end
    @(posedge clk);
    @(negedge clk);
    chk(ta, "ale_o", ale_o, e_ale);
    chk(tp, "psen_n_o", psen_n_o, e_psn);
    chk(tw, "ale_weak_pu_o", ale_weak_pu_o, e_wpu);
  endtask

  task automatic run_cycle(bit ee, bit xd, bit cr, bit dis, bit scramble, string tag);
    for (int ph = 0; ph < 12; ph++) begin
      if (ph == 0 || !scramble)
        step(ph, ee, xd, cr, dis, tag);
      else
        step(ph, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), tag);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    m_ee = 0; m_xd = 0; m_cr = 0; m_dis = 0;
    @(posedge clk);
    @(negedge clk);
    chk("R1", "ale_o", ale_o, 1'b0);
    chk("R1", "psen_n_o", psen_n_o, 1'b1);
    chk("R1", "ale_weak_pu_o", ale_weak_pu_o, 1'b0);
    rst = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5EED_0C51));
    @(negedge clk);
    // reset with hostile inputs, mid-cycle phase
    phase_i = 4'd4; ext_exec_i = 1; xdata_i = 1; ale_dis_i = 1;
    do_reset();
    // directed corner cases
    run_cycle(0, 0, 0, 0, 0, "");        // internal, enabled: R2
    run_cycle(1, 0, 0, 0, 0, "");        // external fetch: R8
    run_cycle(1, 1, 0, 0, 0, "");        // external data cycle: R4, R8
    run_cycle(0, 0, 0, 1, 0, "");        // disabled idle: R5, R6
    run_cycle(0, 1, 0, 1, 0, "");        // disabled but data move: R5
    run_cycle(0, 0, 1, 1, 0, "");        // disabled but table read: R5
    run_cycle(1, 0, 0, 1, 0, "");        // disable ignored: R7
    run_cycle(1, 1, 0, 1, 0, "");        // disable ignored in data cycle: R7
    run_cycle(0, 0, 0, 1, 1, "R3");      // mid-cycle changes ignored
    run_cycle(1, 0, 0, 0, 1, "R3");
    for (int ph = 12; ph < 16; ph++) step(ph, 1, 0, 0, 0, "R10");
    step(13, 0, 1, 0, 1, "R10");         // no capture on out-of-range phase
    run_cycle(0, 0, 0, 0, 0, "");
    // reset in the middle of a disabled cycle
    for (int ph = 0; ph < 5; ph++) step(ph, 0, 0, 0, 1, "");
    do_reset();
    // random traffic
    for (int c = 0; c < 400; c++) begin
      bit ee = 1'($urandom), xd = 1'($urandom), cr = 1'($urandom), dis = 1'($urandom);
      run_cycle(ee, xd, cr, dis, ($urandom % 4) == 0, "");
      if (($urandom % 16) == 0)
        step(12 + int'($urandom % 4), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R10");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule